// File: doc/BRIEF.md
# Conversion Power and Reference Shutdown Controller

This controller sequences power for a serially addressed sampling converter. The conversion core turns on when the serial front end reports an address match. It turns off again as soon as the conversion finishes. Core power follows the same rule whether the converter runs from its own internal reference or from an external one.

When the internal reference is selected, the block also decides whether that reference stays on between conversions. The read/write bit of the address byte is used as a request. A one keeps the reference powered. A zero arms a shutdown, which takes effect only when the master answers a readout byte with a not-acknowledge. The reference wakes on the falling clock edge that closes a matched address byte, so the first conversion after a shutdown is a dummy. A settling counter, clocked by the system clock, then holds the ready flag low until the reference can be trusted.

Top module: `conv_power_ctl`

## Requirements
- R1: While reset is asserted, and on the first cycle after its release, core_en, ref_en and ref_ready are all low.
- R2: core_en goes high on the cycle after an addr_match strobe. It goes low on the cycle after a conv_done strobe. When both strobes arrive together, addr_match wins.
- R3: core_en behaves the same with ext_ref_mode at 1 or at 0.
- R4: With ext_ref_mode = 1 (external reference), ref_en and ref_ready are low on the next cycle and stay low, and rw_bit has no effect on any output. Raising ext_ref_mode while the internal reference is on turns it off on the next cycle.
- R5: With ext_ref_mode = 0, an address with rw_bit = 1 turns the reference on at its ninth falling edge. The reference then stays on through both acknowledge and not-acknowledge from the master.
- R6: With ext_ref_mode = 0, an address with rw_bit = 0 turns the reference on and arms a shutdown. Master feedback is reported as an mst_ack_valid strobe, with mst_nack = 1 meaning not-acknowledge. A not-acknowledge while armed clears ref_en and ref_ready on the next cycle. An acknowledge leaves them unchanged.
- R7: The reference wakes only on an addr_ack_fall strobe that follows an addr_match. An address that is not followed by the ninth falling edge leaves ref_en low.
- R8: ref_ready goes high exactly SETTLE_CYCLES cycles after the cycle in which ref_en rose. ref_ready is never high while ref_en is low.
- R9: A new address that arrives while the settling count is running does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; the block starts in shutdown |
| ext_ref_mode | input | 1 | Strap: 1 = external reference, 0 = internal reference |
| rw_bit | input | 1 | Read/write bit of the received address, valid with addr_match |
| addr_match | input | 1 | One-cycle strobe: a matching address byte was received |
| addr_ack_fall | input | 1 | One-cycle strobe: ninth falling clock edge of the address byte |
| conv_done | input | 1 | One-cycle strobe: the conversion has finished |
| mst_ack_valid | input | 1 | One-cycle strobe: the master acknowledge bit of a readout byte was sampled |
| mst_nack | input | 1 | Value of that bit: 1 = not-acknowledge, 0 = acknowledge |
| core_en | output | 1 | Conversion core power enable |
| ref_en | output | 1 | Internal reference power enable |
| ref_ready | output | 1 | Internal reference has settled |

## Verification
The properties assume that every input strobe lasts one cycle. They also assume that addr_match comes at least one cycle before the addr_ack_fall of the same byte, as a serial front end would produce it. Every stimulus task in the bench drives strobes for exactly one clock and inserts a cycle between the match and the ninth-edge strobe. The bench also keeps the strap stable during a transaction, except in the one case that deliberately switches it while the reference is on. The sweep covers both reference modes, both read/write values and both master responses, starting from reset each time, and uses a short settling count so that the exact ready latency can be counted.

// File: rtl/conv_power_ctl.sv
module conv_power_ctl #(
  parameter int SETTLE_CYCLES = 1_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_ref_mode,
  input  logic rw_bit,
  input  logic addr_match,
  input  logic addr_ack_fall,
  input  logic conv_done,
  input  logic mst_ack_valid,
  input  logic mst_nack,
  output logic core_en,
  output logic ref_en,
  output logic ref_ready
);

  localparam int CW = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic          addr_seen;
  logic          rw_q;
  logic          armed;
  logic [CW-1:0] cnt;

  wire wake = addr_ack_fall & addr_seen & ~ext_ref_mode;
  wire kill = ext_ref_mode | (mst_ack_valid & mst_nack & armed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_en <= 1'b0;
    end else if (addr_match) begin
      core_en <= 1'b1;
    end else if (conv_done) begin
      core_en <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_seen <= 1'b0;
      rw_q      <= 1'b0;
    end else if (addr_match) begin
      addr_seen <= 1'b1;
      rw_q      <= rw_bit;
    end else if (addr_ack_fall) begin
      addr_seen <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_en    <= 1'b0;
      ref_ready <= 1'b0;
      armed     <= 1'b0;
      cnt       <= '0;
    end else if (kill) begin
      ref_en    <= 1'b0;
      ref_ready <= 1'b0;
      armed     <= 1'b0;
      cnt       <= '0;
    end else begin
      if (wake) armed <= ~rw_q;
      if (wake && !ref_en) begin
        ref_en    <= 1'b1;
        ref_ready <= 1'b0;
        cnt       <= '0;
      end else if (ref_en && !ref_ready) begin
        if (cnt == LAST) ref_ready <= 1'b1;
        else             cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/conv_power_ctl_chk.sv
module conv_power_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic ext_ref_mode,
  input logic addr_match,
  input logic conv_done,
  input logic mst_ack_valid,
  input logic mst_nack,
  input logic core_en,
  input logic ref_en,
  input logic ref_ready
);

  AST_CORE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match |=> core_en); // R2
  AST_CORE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && !addr_match |=> !core_en); // R2
  AST_EXT_NO_REF: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ref_mode |=> !ref_en && !ref_ready); // R4
  AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ref_en && !ext_ref_mode && !(mst_ack_valid && mst_nack) |=> ref_en); // R6
  AST_READY_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ready |-> ref_en); // R8
  AST_WAKE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_en) |-> !ref_ready); // R8
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ready && !ext_ref_mode && !(mst_ack_valid && mst_nack) |=> ref_ready); // R9

endmodule

bind conv_power_ctl conv_power_ctl_chk u_chk (.*);

// File: tb/tb_conv_power_ctl.sv
module tb_conv_power_ctl;
  localparam int S = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_ref_mode = 1'b0, rw_bit = 1'b0, addr_match = 1'b0, addr_ack_fall = 1'b0;
  logic conv_done = 1'b0, mst_ack_valid = 1'b0, mst_nack = 1'b0;
  logic core_en, ref_en, ref_ready;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  conv_power_ctl #(.SETTLE_CYCLES(S)) dut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic do_reset();
    rst_n = 1'b0; cyc(); cyc(); rst_n = 1'b1; cyc();
  endtask

  task automatic address(input logic rw, input bit ninth);
    rw_bit = rw; addr_match = 1'b1; cyc(); addr_match = 1'b0; rw_bit = ~rw;
    if (ninth) begin addr_ack_fall = 1'b1; cyc(); addr_ack_fall = 1'b0; end
  endtask

  task automatic done_pulse();
    conv_done = 1'b1; cyc(); conv_done = 1'b0;
  endtask

  task automatic respond(input logic nack);
    mst_ack_valid = 1'b1; mst_nack = nack; cyc(); mst_ack_valid = 1'b0; mst_nack = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc();
    chk("R1 core_en in reset", core_en, 1'b0);
    chk("R1 ref_en in reset", ref_en, 1'b0);
    chk("R1 ref_ready in reset", ref_ready, 1'b0);
    rst_n = 1'b1; cyc();
    chk("R1 core_en after release", core_en, 1'b0);
    chk("R1 ref_en after release", ref_en, 1'b0);

    for (int mode = 0; mode < 2; mode++)
      for (int rw = 0; rw < 2; rw++)
        for (int nk = 0; nk < 2; nk++) begin
          logic exp_ref;
          int k;
          ext_ref_mode = logic'(mode);
          do_reset();
          rw_bit = logic'(rw); addr_match = 1'b1; cyc(); addr_match = 1'b0; rw_bit = logic'(~rw);
          chk("R2 R3 core_en after address", core_en, 1'b1);
          chk("R7 no wake before ninth edge", ref_en, 1'b0);
          addr_ack_fall = 1'b1; cyc(); addr_ack_fall = 1'b0;
          exp_ref = (mode == 0);
          chk("R4 R5 R6 ref_en after ninth edge", ref_en, exp_ref);
          chk("R8 not ready at wake", ref_ready, 1'b0);
          k = 0;
          while (!ref_ready && k < S + 3) begin cyc(); k++; end
          chk_int("R8 R4 ready latency", k, (mode == 0) ? S : S + 3);
          done_pulse();
          chk("R2 R3 core_en after done", core_en, 1'b0);
          respond(logic'(nk));
          exp_ref = (mode == 0) && !(rw == 0 && nk == 1);
          chk(rw == 0 ? "R6 ref_en after response" : "R5 ref_en after response", ref_en, exp_ref);
          chk("R6 R4 ref_ready after response", ref_ready, exp_ref);
        end

    ext_ref_mode = 1'b0;
    do_reset();
    address(1'b1, 1'b0);
    done_pulse();
    cyc(); cyc();
    chk("R7 address without ninth edge", ref_en, 1'b0);

    do_reset();
    begin
      int k;
      address(1'b1, 1'b1);
      k = 0;
      cyc(); cyc(); k += 2;
      address(1'b0, 1'b1); k += 2;
      chk("R9 still settling", ref_ready, 1'b0);
      while (!ref_ready && k < S + 5) begin cyc(); k++; end
      chk_int("R9 count not restarted", k, S);
      respond(1'b1);
      chk("R6 second address armed shutdown", ref_en, 1'b0);
    end

    do_reset();
    address(1'b1, 1'b1);
    cyc();
    ext_ref_mode = 1'b1; cyc();
    chk("R4 strap raised turns ref off", ref_en, 1'b0);
    ext_ref_mode = 1'b0;

    do_reset();
    address(1'b0, 1'b0);
    addr_match = 1'b1; conv_done = 1'b1; cyc(); addr_match = 1'b0; conv_done = 1'b0;
    chk("R2 match wins over done", core_en, 1'b1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule